// File: doc/BRIEF.md
# Phase-Shifted Gray-Scale Column Pulse Generator

This block produces the logic-level drive code for a bank of display columns driven by a bistable panel. A single shared 7-bit phase counter runs for one drive event of 128 counter-clock periods after a synchronous clear. Each column compares the counter with its own stored 6-bit word. From that comparison it picks one of three drive states: high rail, low rail or the resting zero level.

Every column is driven high for exactly 64 counts of the event. The stored word does not set a duty cycle. It moves the start of that 64-count window, so larger words start it later. A polarity input swaps high and low on every column. A force-to-zero input parks every column at the resting level at once, whatever the counter or the words hold. When the event ends, the counter stays at its final value and all columns return to zero until the next clear.

Top module: `gs_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counter goes idle, and every column's drive code reads zero from that edge on.
- R2: A rising clock edge with `clr_n` low restarts the event at count 0. In the cycle that follows, every column drives low (with `invert` low), whatever its word.
- R3: Let k be the number of edges since the clear (k = 0..127). With `invert` low, a column with word W drives high when W < k <= W+64 and drives low for every other k in the event.
- R4: Word 0 gives one low count, then 64 high counts, then 63 low counts. Word 63 gives 64 low counts followed by 64 high counts.
- R5: With a stable word and `invert` low, each column reads high for exactly 64 of the 128 counts of an event.
- R6: While `invert` is high, the high and low codes of every running column are exchanged. The zero code is not affected.
- R7: While `force_zero` is high, every column's code is zero, combinationally and with no clock edge needed. This holds regardless of counter state, `clr_n`, `invert` and the words.
- R8: At the edge that follows count 127, the event ends. The counter holds, and every column reads zero until the next clear.
- R9: Column n drives `drive[2n+1:2n]` with the encoding 2'b00 = zero, 2'b01 = high, 2'b10 = low. The code 2'b11 never appears. Column n's word sits at `col_word[6n+5:6n]`.
- R10: A clear that arrives while an event is running restarts the event at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; leaves the counter idle |
| clr_n | input | 1 | Active-low synchronous counter clear; starts a drive event |
| invert | input | 1 | Swaps high and low drive on every column |
| force_zero | input | 1 | Forces every column to the zero level, asynchronously |
| col_word | input | 6*CHANNELS | Per-column phase words, column n at bits 6n+5:6n |
| drive | output | 2*CHANNELS | Per-column drive code, column n at bits 2n+1:2n |

## Verification
The bench checks the window edges at counts W and W+1 and at W+64 and W+65, including words 0 and 63. An off-by-one compare would shift the window by a count or give 63 or 65 high counts. It also checks the counts just after 127. A counter that wraps would start a second event there instead of going to zero. A clear in the middle of an event is tested too. A design that ignored it would finish the old event. `force_zero` is toggled mid-cycle, so an override that was registered would show a stale drive code for up to a clock period.

// File: rtl/gs_pkg.sv
package gs_pkg;
    localparam int WORD_W    = 6;
    localparam int CNT_W     = WORD_W + 1;
    localparam int EVENT_LEN = 2 ** CNT_W;
    localparam int HIGH_LEN  = 2 ** WORD_W;

    typedef logic [CNT_W:0] ext_t;

    typedef enum logic [1:0] {
        DRV_ZERO = 2'b00,
        DRV_HIGH = 2'b01,
        DRV_LOW  = 2'b10
    } drive_e;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } phase_t;

    // True while the count lies inside the high window that the word selects.
    function automatic logic in_window(input logic [CNT_W-1:0] cnt,
                                       input logic [WORD_W-1:0] w);
        ext_t c, lo, hi;
        c  = ext_t'(cnt);
        lo = ext_t'(w);
        hi = lo + ext_t'(HIGH_LEN);
        return (c > lo) && (c <= hi);
    endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter
    import gs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_n,
    output phase_t ph
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EVENT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (!clr_n) begin
            ph.run <= 1'b1;
            ph.cnt <= '0;
        end else if (ph.run) begin
            if (ph.cnt == LAST) ph.run <= 1'b0;
            else                ph.cnt <= ph.cnt + 1'b1;
        end
    end

    AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (ph.run && ph.cnt == '0));                       // R2
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ph.run && ph.cnt != LAST) |=> (ph.run && ph.cnt == $past(ph.cnt) + 1'b1)); // R3
    AST_HOLD_END: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ph.run) |=> (!ph.run && $stable(ph.cnt)));       // R8
endmodule

// File: rtl/column_drive.sv
module column_drive
    import gs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    input  logic              invert,
    input  logic              force_zero,
    input  logic [WORD_W-1:0] word,
    output drive_e            drv
);
    logic hi_level;

    always_comb begin
        hi_level = in_window(ph.cnt, word) ^ invert;
        if (force_zero || !ph.run) drv = DRV_ZERO;
        else if (hi_level)         drv = DRV_HIGH;
        else                       drv = DRV_LOW;
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (ph.run && ph.cnt == '0 && !invert && !force_zero) |-> drv == DRV_LOW);  // R2
    AST_LAST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ph.run && ph.cnt == CNT_W'(word) + CNT_W'(HIGH_LEN) && !invert && !force_zero)
        |-> drv == DRV_HIGH);                                                     // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ph.run |-> drv == DRV_ZERO);                                             // R8
endmodule

// File: rtl/gs_pulse_gen.sv
module gs_pulse_gen
    import gs_pkg::*;
#(
    parameter int CHANNELS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_n,
    input  logic                         invert,
    input  logic                         force_zero,
    input  logic [CHANNELS*WORD_W-1:0]   col_word,
    output logic [CHANNELS*2-1:0]        drive
);
    phase_t ph;

    phase_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .ph    (ph)
    );

    for (genvar n = 0; n < CHANNELS; n++) begin : g_col
        drive_e d;
        column_drive u_col (
            .clk        (clk),
            .rst        (rst),
            .ph         (ph),
            .invert     (invert),
            .force_zero (force_zero),
            .word       (col_word[n*WORD_W +: WORD_W]),
            .drv        (d)
        );
        assign drive[2*n +: 2] = d;

        AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
            force_zero |-> drive[2*n +: 2] == 2'b00);   // R7
        AST_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
            drive[2*n +: 2] != 2'b11);                  // R9
    end
endmodule

// File: tb/sim_gs_pulse_gen.sv
`timescale 1ns/1ps
module sim_gs_pulse_gen;
    localparam int CH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clr_n = 1'b1;
    logic            invert = 1'b0;
    logic            force_zero = 1'b0;
    logic [CH*6-1:0] col_word = '0;
    logic [CH*2-1:0] drive;

    int errors = 0;
    int checks = 0;
    int bk = 0;
    bit brun = 1'b0;
    int hicnt [CH];

    always #2.5 clk = ~clk;

    gs_pulse_gen #(.CHANNELS(CH)) u0 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .invert(invert),
        .force_zero(force_zero), .col_word(col_word), .drive(drive)
    );

    function automatic logic [1:0] expect_drv(int k, bit run, int w, bit inv, bit f0);
        bit hi;
        if (f0 || !run) return 2'b00;
        hi = (k > w) && (k <= w + 64);
        if (inv) hi = !hi;
        return hi ? 2'b01 : 2'b10;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp, input int col);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s col=%0d k=%0d actual=%b expected=%b", tag, col, bk, act, exp);
        end
    endtask

    // bench model of the counter, applied right after each rising edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin bk = 0; brun = 0; end
        else if (!clr_n) begin bk = 0; brun = 1; end
        else if (brun) begin
            if (bk == 127) brun = 0; else bk++;
        end
        @(negedge clk);
    endtask

    task automatic check_all(input bit quiet);
        for (int i = 0; i < CH; i++) begin
            int w = int'(col_word[i*6 +: 6]);
            logic [1:0] a = drive[2*i +: 2];
            logic [1:0] e = expect_drv(bk, brun, w, invert, force_zero);
            string tag;
            if (force_zero)              tag = "R7";
            else if (!brun)              tag = "R8";
            else if (bk == 0)            tag = "R2";
            else if (invert)             tag = "R6";
            else if (w == 0 || w == 63)  tag = "R4";
            else                         tag = "R3";
            check(tag, a, e, i);
            if (quiet && a == 2'b01) hicnt[i]++;
        end
    endtask

    task automatic run_event(input int e, input bit quiet, input int restart_at);
        bit restarted = 0;
        for (int i = 0; i < CH; i++) begin
            col_word[i*6 +: 6] = (e == 0) ? 6'(i * 9) : 6'($urandom_range(0, 63));
            hicnt[i] = 0;
        end
        if (e == 1) begin col_word[5:0] = 6'd0; col_word[11:6] = 6'd63; end
        clr_n = 1'b0;
        tick();
        clr_n = 1'b1;
        for (int s = 0; s < 134; s++) begin
            invert = quiet ? 1'b0 : 1'($urandom_range(0, 1));
            force_zero = quiet ? 1'b0 : ($urandom_range(0, 7) == 0);
            #1;
            check_all(quiet);
            if (!quiet && s == 40) begin
                force_zero = 1'b1;
                #0.5;
                for (int i = 0; i < CH; i++) check("R7", drive[2*i +: 2], 2'b00, i);
                force_zero = 1'b0;
            end
            clr_n = 1'b1;
            if (restart_at >= 0 && !restarted && brun && bk == restart_at) begin
                clr_n = 1'b0;   // R10: clear mid-event
                restarted = 1;
            end
            tick();
        end
        if (quiet)
            for (int i = 0; i < CH; i++) check("R5", 2'(hicnt[i] == 64 ? 1 : 0), 2'd1, i);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) tick();
        check_all(1'b0);   // R1, R9: all columns at 2'b00 under reset
        rst = 1'b0;
        tick();
        check_all(1'b0);   // R1: idle after reset release
        run_event(0, 1'b1, -1);
        run_event(1, 1'b1, -1);
        run_event(2, 1'b1, -1);
        run_event(3, 1'b0, 50);   // R10
        for (int e = 4; e < 12; e++) run_event(e, 1'b0, (e == 7) ? 100 : -1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #750000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule